// File: doc/BRIEF.md
# Cascadable Presettable Modulo-16 Counter

This block is a small up counter that steps through sixteen states and rolls over from fifteen back to zero. A parallel input lets it start from any state, and two separate count enables let several copies form one wider synchronous counter.

The first count enable (`cnt_en_p`) only gates counting. The second (`cnt_en_t`) gates counting and also qualifies the terminal-count flag (`term_o`). To chain stages, connect each stage's `term_o` to the next stage's `cnt_en_t`, so that a higher stage advances only on the cycle when every lower stage is at all ones.

A build parameter selects how the single active-low reset (`rst_n`) acts. It can be a clear that acts only on the clock edge, or an immediate clear that does not wait for the clock. In both forms the order of precedence is fixed: clear first, then load, then count, then hold.

Top module: `cascade_counter`

## Requirements
- R1: With ASYNC_RESET=0, `rst_n` low at a rising clock edge sets `q` to 0 on that edge, even when load and both enables are active. Dropping `rst_n` between edges leaves `q` unchanged until the next edge.
- R2: When `rst_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, whatever the count enables are.
- R3: When `rst_n` and `load_n` are both high and both count enables are high, `q` increases by one at the edge.
- R4: When `rst_n` and `load_n` are both high and either count enable is low, `q` keeps its value across the edge.
- R5: Counting from state 15 gives state 0.
- R6: `term_o` is 1 exactly when `q` is 15 and `cnt_en_t` is 1. It follows a change on `cnt_en_t` within the same cycle, with no clock edge needed.
- R7: `term_o` does not depend on `cnt_en_p`.
- R8: With ASYNC_RESET=1, `rst_n` low forces `q` to 0 at once, with no clock edge. `q` stays 0 across edges while `rst_n` is low, even when load is requested. Loading works again after release.
- R9: Two stages chained by connecting `term_o` to the next stage's `cnt_en_t`, with a shared `cnt_en_p` and `load_n`, count as one 8-bit counter. That counter wraps from 255 to 0 and holds whenever the shared enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; synchronous or asynchronous, chosen by ASYNC_RESET |
| load_n | input | 1 | Active-low parallel load |
| cnt_en_p | input | 1 | Count enable that gates counting only |
| cnt_en_t | input | 1 | Count enable that gates counting and qualifies `term_o` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Counter state |
| term_o | output | 1 | Terminal count: `q` all ones and `cnt_en_t` high |

## Verification
Two functions can be requested on the same clock edge: a parallel load together with an increment, or a clear together with a load. The bench sweeps every start state against all eight combinations of `load_n` and the two enables. It then predicts the next state from the precedence order alone, so every edge where load and count are both requested must show the loaded value.

Clear against load is provoked by lowering `rst_n` while a load is also requested. In the synchronous form the result is judged before and after the edge. In the immediate form it is judged mid-cycle and again across an edge.

// File: rtl/ccnt_pkg.sv
// Package: shared types for the cascadable counter.
// Assumes: only the four operating modes below exist.
package ccnt_pkg;
    typedef enum logic [1:0] {
        CM_HOLD  = 2'd0,
        CM_COUNT = 2'd1,
        CM_LOAD  = 2'd2,
        CM_CLEAR = 2'd3
    } ccnt_mode_e;
endpackage

// File: rtl/ccnt_mode_sel.sv
// Module: ccnt_mode_sel
// Picks the operating mode for the next edge in fixed precedence:
// clear, then load, then count, then hold.
// Assumes: all controls are active as named (rst_n, load_n active low).
module ccnt_mode_sel
    import ccnt_pkg::*;
(
    input  logic       rst_n,
    input  logic       load_n,
    input  logic       en_par,
    input  logic       en_trk,
    output ccnt_mode_e mode
);
    // Priority decode of the control inputs.
    always_comb begin
        if (!rst_n)                mode = CM_CLEAR;
        else if (!load_n)          mode = CM_LOAD;
        else if (en_par && en_trk) mode = CM_COUNT;
        else                       mode = CM_HOLD;
    end
endmodule

// File: rtl/ccnt_state_reg.sv
// Module: ccnt_state_reg
// Holds the counter state and applies the selected mode on the rising edge.
// Assumes: ASYNC_RESET=1 adds an immediate clear on rst_n low; otherwise
// clearing is done only through the CM_CLEAR mode at the edge.
module ccnt_state_reg
    import ccnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ccnt_mode_e       mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_nxt;

    // Next-state selection from the decoded mode.
    always_comb begin
        unique case (mode)
            CM_CLEAR: q_nxt = '0;
            CM_LOAD:  q_nxt = din;
            CM_COUNT: q_nxt = q_r + STEP;
            default:  q_nxt = q_r;
        endcase
    end

    generate
        if (ASYNC_RESET) begin : g_async_clr
            // State flops with an immediate clear.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= q_nxt;
            end
        end else begin : g_sync_clr
            // State flops; clearing arrives through the mode decode.
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end
    endgenerate

    assign q = q_r;
endmodule

// File: rtl/ccnt_term_dec.sv
// Module: ccnt_term_dec
// Flags the terminal state (all ones) qualified by the trickle enable.
// Assumes: purely combinational; glitches are possible, so not for clocking.
module ccnt_term_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_trk,
    output logic             term
);
    // AND of every state bit with the trickle enable.
    always_comb term = (&q) & en_trk;
endmodule

// File: rtl/cascade_counter.sv
// Module: cascade_counter (top)
// Presettable wrapping up counter with two count enables and a
// terminal-count output for chaining stages.
// Assumes: WIDTH=4 gives the modulo-16 sequence; ASYNC_RESET picks the clear style.
module cascade_counter
    import ccnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en_p,
    input  logic             cnt_en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             term_o
);
    ccnt_mode_e mode;

    ccnt_mode_sel u_mode (
        .rst_n  (rst_n),
        .load_n (load_n),
        .en_par (cnt_en_p),
        .en_trk (cnt_en_t),
        .mode   (mode)
    );

    ccnt_state_reg #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .din   (din),
        .q     (q)
    );

    ccnt_term_dec #(.WIDTH(WIDTH)) u_term (
        .q      (q),
        .en_trk (cnt_en_t),
        .term   (term_o)
    );
endmodule

// File: rtl/cascade_counter_chk.sv
// Module: cascade_counter_chk
// Port-level properties for cascade_counter, attached by bind.
module cascade_counter_chk #(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             cnt_en_p,
    input logic             cnt_en_t,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             term_o
);
    logic [WIDTH-1:0] q_plus;
    assign q_plus = q + WIDTH'(1);

    // R1 and R8: reset seen at an edge leaves zero afterwards
    a_r1_clear_at_edge: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: load takes the preset value
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |=> (q == $past(din)));

    // R3: counting steps by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t) |=> (q == $past(q_plus)));

    // R4: either enable low holds
    a_r4_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q));

    // R5: all ones wraps to zero when counting
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_p && cnt_en_t && (q == '1)) |=> (q == '0));

    // R6: terminal flag only in the all-ones state with trickle enable
    a_r6_term_qual: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |-> ((q == '1) && cnt_en_t));

    generate
        if (ASYNC_RESET) begin : g_async_chk
            // R8: immediate clear is visible mid-cycle
            a_r8_async_clear: assert property (@(negedge clk)
                !rst_n |-> (q == '0));
        end
    endgenerate
endmodule

bind cascade_counter cascade_counter_chk #(
    .WIDTH       (WIDTH),
    .ASYNC_RESET (ASYNC_RESET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .cnt_en_p (cnt_en_p),
    .cnt_en_t (cnt_en_t),
    .din      (din),
    .q        (q),
    .term_o   (term_o)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
    logic       clk = 1'b0;
    logic       rst_n, a_rst_n, load_n, en_p, en_t;
    logic [3:0] din_lo, din_hi, q_lo, q_hi, q_a;
    logic       tc_lo, tc_hi, tc_a;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    cascade_counter dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din_lo), .q(q_lo), .term_o(tc_lo));

    cascade_counter u_hi (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(tc_lo), .din(din_hi), .q(q_hi), .term_o(tc_hi));

    cascade_counter #(.ASYNC_RESET(1'b1)) u_async (
        .clk(clk), .rst_n(a_rst_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din_lo), .q(q_a), .term_o(tc_a));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        rst_n = 1'b0; a_rst_n = 1'b0; load_n = 1'b1;
        en_p = 1'b0; en_t = 1'b0; din_lo = '0; din_hi = '0;
        tick(); tick();
        chk("R1 reset q", q_lo, 0);
        chk("R1 reset term", tc_lo, 0);
        chk("R8 reset q", q_a, 0);
        rst_n = 1'b1; a_rst_n = 1'b1;

        // Sweep all start states against every control combination.
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 8; c++) begin
                int d, e;
                load_n = 1'b0; din_lo = 4'(s); en_p = 1'b0; en_t = 1'b0;
                tick();
                chk("R2 preset", q_lo, s);
                d = (s * 5 + 3) % 16;
                load_n = c[2]; en_p = c[1]; en_t = c[0]; din_lo = 4'(d);
                #1;
                chk("R6 R7 term", tc_lo, (s == 15 && c[0]) ? 1 : 0);
                tick();
                if (!c[2])             e = d;
                else if (c[1] && c[0]) e = (s + 1) % 16;
                else                   e = s;
                chk(!c[2] ? "R2 load wins" : (c[1] && c[0]) ?
                    (s == 15 ? "R5 wrap" : "R3 count") : "R4 hold", q_lo, e);
                chk("R2 R3 R4 async variant", q_a, e);
            end
        end

        // Trickle enable moves term within the cycle; parallel enable does not.
        load_n = 1'b0; din_lo = 4'd15; en_p = 1'b0; en_t = 1'b0;
        tick();
        load_n = 1'b1;
        #1; chk("R6 term low", tc_lo, 0);
        en_t = 1'b1; #1; chk("R6 term rise", tc_lo, 1);
        en_p = 1'b1; #1; chk("R7 term with par", tc_lo, 1);
        en_p = 1'b0; #1; chk("R7 term without par", tc_lo, 1);
        en_t = 1'b0;

        // Synchronous clear beats a simultaneous load and count.
        load_n = 1'b0; din_lo = 4'd6;
        tick();
        rst_n = 1'b0; din_lo = 4'd9; en_p = 1'b1; en_t = 1'b1;
        #5; chk("R1 no change before edge", q_lo, 6);
        tick();
        chk("R1 clear beats load", q_lo, 0);
        rst_n = 1'b1; en_p = 1'b0; en_t = 1'b0;

        // Immediate clear in the asynchronous variant.
        load_n = 1'b0; din_lo = 4'd9;
        tick();
        chk("R8 preset", q_a, 9);
        a_rst_n = 1'b0;
        #1; chk("R8 immediate clear", q_a, 0);
        en_p = 1'b1; en_t = 1'b1;
        tick();
        chk("R8 held over load", q_a, 0);
        a_rst_n = 1'b1; din_lo = 4'd4; en_p = 1'b0; en_t = 1'b0;
        tick();
        chk("R8 load after release", q_a, 4);

        // Two chained stages form one 8-bit counter.
        load_n = 1'b0; din_lo = '0; din_hi = '0;
        tick();
        chk("R9 start", {q_hi, q_lo}, 0);
        load_n = 1'b1; en_t = 1'b1;
        k = 0;
        for (int i = 0; i < 300; i++) begin
            logic stall;
            stall = (i % 37 == 36);
            en_p = !stall;
            tick();
            if (!stall) k = (k + 1) % 256;
            chk(k == 0 ? "R9 wrap" : "R9 count", {q_hi, q_lo}, k);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule